// File: doc/BRIEF.md
# Multi-Link Bank-Switch Sync Controller

This block is the register-mapped control point for a host audio controller that drives up to four serial audio bus links. Software uses one register to ask each link to power up and to watch for the power-up to complete. A second, shared register holds the frame sync period, a trigger that loads a new period into the live timing, one arm bit per link, and a single go bit. When software writes the go bit, every armed link receives a bank-switch strobe in the same clock cycle. The hardware then clears all the arm bits and the go bit itself, so a driver that loops over its links can fire the switch once and find nothing left to clear.

The register port is a plain, always-ready 32-bit write/read interface. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr` and never stalls. There is no streaming data path, so the block has no valid/ready handshake and no back-pressure. The power request and power-on status, the live sync period and the bank-switch strobes are plain level or pulse pins toward the link engines.

Register map by byte address: 0x0 is link control and 0x4 is sync. Every other address reads zero and ignores writes.

Top module: `mlink_sync_ctrl`

## Requirements
- R1: After reset, link control reads 0x00000000, sync reads 0x0000176F, `sync_period` is 0x176F, and `link_pwr_req`, `link_pwr_on` and `bank_sw` are all zero.
- R2: In link control, bit N is the power request for link N. It reads back as written and drives `link_pwr_req[N]` from the cycle after the write.
- R3: Power status for link N reads at bit 8+N of link control and on `link_pwr_on[N]`. It rises exactly PWR_DELAY cycles after the write edge that sets the request, and it never changes unless the request differs from it.
- R4: Clearing a power request drops the matching status exactly PWR_DELAY cycles after the write edge.
- R5: Sync bits 14:0 hold the programmed period and read back as written. Writing them alone leaves `sync_period` unchanged.
- R6: Writing 1 to sync bit 15 makes that bit read 1 for exactly LOAD_DELAY cycles. When it clears, `sync_period` takes the programmed period, and `sync_period` changes at no other time.
- R7: Sync bits 16+N are the arm bits for link N. A write stores them and they read back.
- R8: Writing 1 to sync bit 24 (go) makes it read 1 for one cycle. It then clears itself, and every arm bit clears at the same edge.
- R9: Go drives `bank_sw` high for exactly one cycle on all armed links at once, in the cycle right after go reads 1. A strobe never occurs without a go.
- R10: A go with no arm bit set clears after one cycle and produces no strobe.
- R11: A single write that sets both arm bits and go strobes those same links.
- R12: Reserved bits of both registers read zero and ignore writes. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Byte address (0x0 link control, 0x4 sync) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| link_pwr_req | output | NUM_LINKS | Power request to each link |
| link_pwr_on | output | NUM_LINKS | Power-on status per link |
| sync_period | output | 15 | Live sync period used by the link engines |
| bank_sw | output | NUM_LINKS | One-cycle bank-switch strobe per link |

## Verification
The assertions check on every cycle the following:
- a go bit never lasts more than one cycle on its own;
- a strobe appears only right after a go, carries exactly the arm pattern that go saw, and lasts one cycle;
- arms are empty after a go;
- power status never moves unless the request differs from it;
- the live period changes only as a load completes;
- reserved sync bits always read zero.

Only the bench scenarios can show the exact PWR_DELAY and LOAD_DELAY latencies, the readback of written fields, and the silence of a go with nothing armed. The scenarios also cover an arm-and-go combined in one write and the reset values. The bench scoreboard ties each expected strobe to its cycle.

// File: rtl/mlsc_pkg.sv
`timescale 1ns/1ps
package mlsc_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned PERIOD_W   = 15;
  localparam logic [PERIOD_W-1:0] PERIOD_RST = 15'h176F;
  localparam int unsigned LOAD_BIT   = 15;
  localparam int unsigned ARM_LSB    = 16;
  localparam int unsigned ARM_SLOTS  = 4;
  localparam int unsigned GO_BIT     = 24;
  localparam int unsigned STAT_LSB   = 8;
  localparam logic [3:0]  OFS_LINK   = 4'h0;
  localparam logic [3:0]  OFS_SYNC   = 4'h4;

  typedef enum logic [1:0] {SEL_NONE, SEL_LINK, SEL_SYNC} reg_sel_e;
endpackage

// File: rtl/mlsc_link_power.sv
`timescale 1ns/1ps
module mlsc_link_power #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic on
);
  localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          on_q;

  // Status follows the request after DELAY edges of continuous mismatch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (req == on_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      on_q  <= req;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign on = on_q;
endmodule

// File: rtl/mlsc_period_load.sv
`timescale 1ns/1ps
module mlsc_period_load
  import mlsc_pkg::*;
#(
  parameter int unsigned LOAD_DELAY = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PERIOD_W-1:0] wr_period,
  input  logic                wr_load,
  output logic [PERIOD_W-1:0] prog_o,
  output logic                busy_o,
  output logic [PERIOD_W-1:0] active_o
);
  localparam int unsigned CW = (LOAD_DELAY > 1) ? $clog2(LOAD_DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOAD_DELAY - 1);

  logic [PERIOD_W-1:0] prog_q, active_q;
  logic                busy_q;
  logic [CW-1:0]       cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q   <= PERIOD_RST;
      active_q <= PERIOD_RST;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (wr_en) prog_q <= wr_period;
      if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q   <= 1'b0;
          cnt_q    <= '0;
          active_q <= prog_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (wr_en && wr_load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign prog_o   = prog_q;
  assign busy_o   = busy_q;
  assign active_o = active_q;
endmodule

// File: rtl/mlsc_bank_sync.sv
`timescale 1ns/1ps
module mlsc_bank_sync #(
  parameter int unsigned NUM_LINKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_LINKS-1:0] wr_arm,
  input  logic                 wr_go,
  output logic [NUM_LINKS-1:0] arm_o,
  output logic                 go_o,
  output logic [NUM_LINKS-1:0] strobe_o
);
  logic [NUM_LINKS-1:0] arm_q, arm_d, strobe_q;
  logic                 go_q, go_d;

  // A pending go empties the arms first; a write in the same cycle then lands on top.
  always_comb begin
    arm_d = go_q ? '0 : arm_q;
    go_d  = 1'b0;
    if (wr_en) begin
      arm_d = wr_arm;
      go_d  = wr_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q    <= '0;
      go_q     <= 1'b0;
      strobe_q <= '0;
    end else begin
      arm_q    <= arm_d;
      go_q     <= go_d;
      strobe_q <= go_q ? arm_q : '0;
    end
  end

  assign arm_o    = arm_q;
  assign go_o     = go_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/mlink_sync_ctrl.sv
`timescale 1ns/1ps
module mlink_sync_ctrl
  import mlsc_pkg::*;
#(
  parameter int unsigned NUM_LINKS  = 4,
  parameter int unsigned PWR_DELAY  = 16,
  parameter int unsigned LOAD_DELAY = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINKS-1:0] link_pwr_req,
  output logic [NUM_LINKS-1:0] link_pwr_on,
  output logic [14:0]          sync_period,
  output logic [NUM_LINKS-1:0] bank_sw
);
  reg_sel_e             sel;
  logic                 wr_link, wr_sync;
  logic [NUM_LINKS-1:0] req_q;
  logic [NUM_LINKS-1:0] arm_q;
  logic                 go_q;
  logic                 load_busy;
  logic [PERIOD_W-1:0]  prog_period;
  logic                 unused_wdata;

  always_comb begin
    unique case (reg_addr)
      OFS_LINK: sel = SEL_LINK;
      OFS_SYNC: sel = SEL_SYNC;
      default:  sel = SEL_NONE;
    endcase
  end

  assign wr_link      = reg_wr && (sel == SEL_LINK);
  assign wr_sync      = reg_wr && (sel == SEL_SYNC);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_q <= '0;
    else if (wr_link) req_q <= reg_wdata[NUM_LINKS-1:0];
  end

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    mlsc_link_power #(.DELAY(PWR_DELAY)) u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_q[i]),
      .on    (link_pwr_on[i])
    );
  end

  mlsc_period_load #(.LOAD_DELAY(LOAD_DELAY)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_sync),
    .wr_period (reg_wdata[PERIOD_W-1:0]),
    .wr_load   (reg_wdata[LOAD_BIT]),
    .prog_o    (prog_period),
    .busy_o    (load_busy),
    .active_o  (sync_period)
  );

  mlsc_bank_sync #(.NUM_LINKS(NUM_LINKS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_sync),
    .wr_arm   (reg_wdata[ARM_LSB +: NUM_LINKS]),
    .wr_go    (reg_wdata[GO_BIT]),
    .arm_o    (arm_q),
    .go_o     (go_q),
    .strobe_o (bank_sw)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_LINK: begin
        reg_rdata[NUM_LINKS-1:0]         = req_q;
        reg_rdata[STAT_LSB +: NUM_LINKS] = link_pwr_on;
      end
      SEL_SYNC: begin
        reg_rdata[PERIOD_W-1:0]         = prog_period;
        reg_rdata[LOAD_BIT]             = load_busy;
        reg_rdata[ARM_LSB +: NUM_LINKS] = arm_q;
        reg_rdata[GO_BIT]               = go_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign link_pwr_req = req_q;
endmodule

// File: rtl/mlsc_checker.sv
`timescale 1ns/1ps
module mlsc_checker #(
  parameter int unsigned NUM_LINKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [3:0]           reg_addr,
  input logic [31:0]          reg_rdata,
  input logic [NUM_LINKS-1:0] link_pwr_req,
  input logic [NUM_LINKS-1:0] link_pwr_on,
  input logic [14:0]          sync_period,
  input logic [NUM_LINKS-1:0] bank_sw,
  input logic [NUM_LINKS-1:0] arm_q,
  input logic                 go_q,
  input logic                 load_busy
);
  localparam logic [31:0] SYNC_MASK =
    32'h0100_FFFF | (((32'h1 << NUM_LINKS) - 32'h1) << 16);

  logic sync_wr;
  assign sync_wr = reg_wr && (reg_addr == 4'h4);

  AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    go_q && !sync_wr |=> !go_q); // R8

  AST_ARMS_EMPTY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go_q && !sync_wr |=> arm_q == '0); // R8

  AST_STROBE_MATCHES_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> bank_sw == $past(arm_q)); // R9

  AST_STROBE_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sw != '0) |-> $past(go_q)); // R10

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sw != '0) && !go_q |=> bank_sw == '0); // R9

  AST_STATUS_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((link_pwr_on ^ $past(link_pwr_on)) &
     ~($past(link_pwr_req) ^ $past(link_pwr_on))) == '0); // R3

  AST_PERIOD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_period != $past(sync_period) |-> $past(load_busy) && !load_busy); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 4'h4 |-> (reg_rdata & ~SYNC_MASK) == 32'h0); // R12
endmodule

bind mlink_sync_ctrl mlsc_checker #(.NUM_LINKS(NUM_LINKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .link_pwr_req (link_pwr_req),
  .link_pwr_on  (link_pwr_on),
  .sync_period  (sync_period),
  .bank_sw      (bank_sw),
  .arm_q        (arm_q),
  .go_q         (go_q),
  .load_busy    (load_busy)
);

// File: tb/sim_mlink_sync_ctrl.sv
`timescale 1ns/1ps
module sim_mlink_sync_ctrl;
  localparam int NL = 4;
  localparam int PD = 16;
  localparam int LD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] link_pwr_req, link_pwr_on, bank_sw;
  logic [14:0] sync_period;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { logic [NL-1:0] vec; int at; } strobe_t;
  strobe_t exp_q[$];

  mlink_sync_ctrl #(.NUM_LINKS(NL), .PWR_DELAY(PD), .LOAD_DELAY(LD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_pwr_req(link_pwr_req),
    .link_pwr_on(link_pwr_on), .sync_period(sync_period), .bank_sw(bank_sw)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Driver side of the scoreboard: a go write expects its strobe one cycle later.
  task automatic go_write(input logic [31:0] d, input logic [NL-1:0] exp_vec);
    strobe_t s;
    wr(4'h4, d);
    if (exp_vec != '0) begin
      s.vec = exp_vec;
      s.at  = cyc + 1;
      exp_q.push_back(s);
    end
  endtask

  // Monitor: every strobe seen must match the head of the queue, in its cycle.
  always @(negedge clk) begin
    if (rst_n && !done && bank_sw != '0) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R9/R10 unexpected strobe actual=0x%0h expected=0x0", bank_sw);
      end else begin
        strobe_t s;
        s = exp_q.pop_front();
        if (s.vec !== bank_sw || s.at != cyc) begin
          n_errors++;
          $display("FAIL R9 strobe actual=0x%0h@%0d expected=0x%0h@%0d",
                   bank_sw, cyc, s.vec, s.at);
        end
      end
    end
  end

  task automatic finish_sim;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(4'h0, d); check("R1 link ctrl", d, 32'h0);
    rd(4'h4, d); check("R1 sync", d, 32'h0000_176F);
    check("R1 sync_period", {17'h0, sync_period}, 32'h176F);
    check("R1 outputs", {20'h0, link_pwr_req, link_pwr_on, bank_sw}, 32'h0);

    // R12 / R2 reserved bits of link control
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R12 link reserved", d, 32'h0000_000F);
    check("R2 pwr_req pins", {28'h0, link_pwr_req}, 32'hF);
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R2 request cleared", d, 32'h0);
    rd(4'h8, d); check("R12 unmapped read", d, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R12 unmapped write link", d, 32'h0);
    rd(4'h4, d); check("R12 unmapped write sync", d, 32'h0000_176F);
    wr(4'h4, 32'hFEF0_176F);
    rd(4'h4, d); check("R12 sync reserved", d, 32'h0000_176F);

    // R3 power-up latency on link 1
    wr(4'h0, 32'h2);
    repeat (PD - 1) @(negedge clk);
    rd(4'h0, d); check("R3 status before delay", d, 32'h0000_0002);
    @(negedge clk);
    rd(4'h0, d); check("R3 status after delay", d, 32'h0000_0202);
    check("R3 pwr_on pin", {28'h0, link_pwr_on}, 32'h2);

    // R4 power-down latency
    wr(4'h0, 32'h0);
    repeat (PD - 1) @(negedge clk);
    rd(4'h0, d); check("R4 status still on", d, 32'h0000_0200);
    @(negedge clk);
    rd(4'h0, d); check("R4 status off", d, 32'h0);

    // R5 period write without load
    wr(4'h4, 32'h0000_1234);
    rd(4'h4, d); check("R5 period readback", d, 32'h0000_1234);
    check("R5 live period kept", {17'h0, sync_period}, 32'h176F);

    // R6 load trigger
    wr(4'h4, 32'h0000_8ABC);
    rd(4'h4, d); check("R6 load busy", d, 32'h0000_8ABC);
    repeat (LD - 1) @(negedge clk);
    rd(4'h4, d); check("R6 busy before delay", d, 32'h0000_8ABC);
    check("R6 live before load", {17'h0, sync_period}, 32'h176F);
    @(negedge clk);
    rd(4'h4, d); check("R6 load done", d, 32'h0000_0ABC);
    check("R6 live after load", {17'h0, sync_period}, 32'h0ABC);

    // R7 arm bits
    wr(4'h4, 32'h0005_0ABC);
    rd(4'h4, d); check("R7 arm readback", d, 32'h0005_0ABC);
    check("R7 no strobe on arm", {28'h0, bank_sw}, 32'h0);

    // R8 / R9 go with arms already set
    go_write(32'h0105_0ABC, 4'h5);
    rd(4'h4, d); check("R8 go reads 1", d, 32'h0105_0ABC);
    @(negedge clk);
    rd(4'h4, d); check("R8 go and arms cleared", d, 32'h0000_0ABC);
    check("R9 strobe pins", {28'h0, bank_sw}, 32'h5);

    // R10 go with nothing armed
    go_write(32'h0100_0ABC, 4'h0);
    rd(4'h4, d); check("R10 go reads 1", d, 32'h0100_0ABC);
    @(negedge clk);
    rd(4'h4, d); check("R10 go cleared", d, 32'h0000_0ABC);
    check("R10 no strobe", {28'h0, bank_sw}, 32'h0);

    // R11 arm and go in one write, then all links
    go_write(32'h010A_0ABC, 4'hA);
    @(negedge clk);
    check("R11 combined strobe", {28'h0, bank_sw}, 32'hA);
    go_write(32'h010F_0ABC, 4'hF);
    @(negedge clk);
    check("R9 all links together", {28'h0, bank_sw}, 32'hF);
    @(negedge clk);
    check("R9 strobe one cycle", {28'h0, bank_sw}, 32'h0);

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 32'h0);
    finish_sim();
  end
endmodule